// File: doc/BRIEF.md
# MSI Remap Request Dispatcher

This block sorts incoming message-signalled interrupt requests before any remapping table is read. Each request brings a 64-bit message address, a 32-bit message data word and a 16-bit source ID. It also brings the four 64-bit words of the device table entry that a neighbouring lookup unit has already fetched for that source. Two configuration levels are also inputs: whether a device table exists, and whether the unit supports interrupt remapping at all.

From these inputs the block picks one of four outcomes: forward the message untouched, send it to the remap fetch unit, target-abort it, or flag a general error. The choice depends on the delivery mode carried in the message data. Fixed and arbitrated interrupts follow a two-bit control field in the entry. NMI, INIT and external interrupts follow their own pass-through enable bits. SMI is always refused. The result is registered and appears one cycle after the request, together with a one-cycle valid strobe.

Top module: `msi_remap_dispatch`

## Requirements
- R1: `lookup_sid` follows `req_sid` combinationally, except that the reserved value `INVALID_SID` (default 16'hFFFF) is replaced by `IOAPIC_SID` (default 16'h00A0).
- R2: When `table_on` is 0, or bit 0 of entry word 2 is 0, the outcome is pass (code 0), and `pass_addr`/`pass_data` equal the request's address and data.
- R3: With a table present and entry word 2 bit 0 set, a cleared `remap_cap` gives general error (code 3).
- R4: With a table present and entry word 2 bit 0 set, a nonzero upper half of the address (bits 63:32) gives general error.
- R5: The delivery mode is data bits 10:8. Values 2 (SMI), 3 and 6 give general error.
- R6: For modes 0 and 1, entry word 2 bits 61:60 select the outcome: 0 gives abort (code 2), 1 gives pass, 2 gives remap (code 1), 3 gives general error. Address bit 2 is not examined for these modes.
- R7: A remap outcome raises `remap_valid` together with `res_valid`. It presents `remap_sid` (the substituted ID), `remap_root` equal to entry word 2 bits 50:6, and `remap_index` equal to data bits 10:0. `remap_valid` is 0 for every other outcome.
- R8: For modes 4 (NMI), 5 (INIT) and 7 (external), address bit 2 set gives general error.
- R9: For those modes with address bit 2 clear, entry word 3 bit 58 (NMI), bit 56 (INIT) or bit 57 (external) set gives pass. If the bit is clear, the outcome is general error.
- R10: `res_valid` is high for exactly the cycle after each cycle in which `req_valid` is high. `res_err` is 1 for general error, 3 for abort and 0 otherwise.
- R11: During and after reset, `res_valid` and `remap_valid` are 0 until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Message address |
| req_data | input | 32 | Message data |
| req_sid | input | 16 | Requester source ID |
| table_on | input | 1 | A device table is configured |
| remap_cap | input | 1 | Unit supports interrupt remapping |
| dte_w0 | input | 64 | Device table entry word 0 |
| dte_w1 | input | 64 | Device table entry word 1 |
| dte_w2 | input | 64 | Entry word 2: enable, table root, control field |
| dte_w3 | input | 64 | Entry word 3: pass-through enables |
| lookup_sid | output | 16 | Source ID to use for the table lookup |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 0 pass, 1 remap, 2 abort, 3 error |
| res_err | output | 2 | 0 none, 1 general error, 3 target abort |
| pass_addr | output | 64 | Address forwarded on pass |
| pass_data | output | 32 | Data forwarded on pass |
| remap_valid | output | 1 | Request strobe to the remap fetch unit |
| remap_sid | output | 16 | Source ID for the fetch |
| remap_root | output | 45 | Remap table root (entry word 2 bits 50:6) |
| remap_index | output | 11 | Table index (data bits 10:0) |

## Verification
The bench sweeps every combination of the following: table presence, entry enable, remap capability, a high address half, all eight delivery modes, all four control values, the destination-mode bit and all eight pass-enable patterns. Each outcome is compared against a model built from the requirements.

The corner cases it targets are these:
- The priority of pass-through over the capability check. A design that checked capability first would report errors for devices that never enabled remapping.
- The mapping of NMI, INIT and external modes onto bits 58, 56 and 57. Swapping any two bits would pass or reject the wrong interrupt type.
- The fact that the destination-mode bit is ignored for fixed and arbitrated modes. Checking it there would turn valid remaps into errors.
- Source ID substitution, and the fact that the remap strobe appears only for remap outcomes. An unguarded strobe would send fetches for passed or aborted messages.

// File: rtl/msi_remap_dispatch.sv
module msi_remap_dispatch #(
  parameter logic [15:0] INVALID_SID = 16'hFFFF,
  parameter logic [15:0] IOAPIC_SID  = 16'h00A0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_addr,
  input  logic [31:0] req_data,
  input  logic [15:0] req_sid,
  input  logic        table_on,
  input  logic        remap_cap,
  input  logic [63:0] dte_w0,
  input  logic [63:0] dte_w1,
  input  logic [63:0] dte_w2,
  input  logic [63:0] dte_w3,
  output logic [15:0] lookup_sid,
  output logic        res_valid,
  output logic [1:0]  res_kind,
  output logic [1:0]  res_err,
  output logic [63:0] pass_addr,
  output logic [31:0] pass_data,
  output logic        remap_valid,
  output logic [15:0] remap_sid,
  output logic [44:0] remap_root,
  output logic [10:0] remap_index
);

  localparam logic [1:0] K_PASS  = 2'd0;
  localparam logic [1:0] K_REMAP = 2'd1;
  localparam logic [1:0] K_ABORT = 2'd2;
  localparam logic [1:0] K_ERROR = 2'd3;

  logic [2:0] mode;
  logic [1:0] ctl;
  logic       dmode;
  logic       gated;
  logic [1:0] kind;
  logic       unused_bits;

  assign lookup_sid = (req_sid == INVALID_SID) ? IOAPIC_SID : req_sid;
  assign mode  = req_data[10:8];
  assign ctl   = dte_w2[61:60];
  assign dmode = req_addr[2];
  assign gated = table_on && dte_w2[0];

  assign unused_bits = ^{dte_w0, dte_w1, dte_w2[63:62], dte_w2[59:51], dte_w2[5:1],
                         dte_w3[63:59], dte_w3[55:0], req_data[31:11]};

  always_comb begin
    kind = K_PASS;
    if (!gated)
      kind = K_PASS;
    else if (!remap_cap || (req_addr[63:32] != 32'd0))
      kind = K_ERROR;
    else begin
      case (mode)
        3'd0, 3'd1: begin
          case (ctl)
            2'd0:    kind = K_ABORT;
            2'd1:    kind = K_PASS;
            2'd2:    kind = K_REMAP;
            default: kind = K_ERROR;
          endcase
        end
        3'd4:    kind = (!dmode && dte_w3[58]) ? K_PASS : K_ERROR;
        3'd5:    kind = (!dmode && dte_w3[56]) ? K_PASS : K_ERROR;
        3'd7:    kind = (!dmode && dte_w3[57]) ? K_PASS : K_ERROR;
        default: kind = K_ERROR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      remap_valid <= 1'b0;
      res_kind    <= K_PASS;
      res_err     <= 2'd0;
      pass_addr   <= 64'd0;
      pass_data   <= 32'd0;
      remap_sid   <= 16'd0;
      remap_root  <= 45'd0;
      remap_index <= 11'd0;
    end else begin
      res_valid   <= req_valid;
      remap_valid <= req_valid && (kind == K_REMAP);
      if (req_valid) begin
        res_kind    <= kind;
        res_err     <= (kind == K_ERROR) ? 2'd1 : (kind == K_ABORT) ? 2'd3 : 2'd0;
        pass_addr   <= req_addr;
        pass_data   <= req_data;
        remap_sid   <= lookup_sid;
        remap_root  <= dte_w2[50:6];
        remap_index <= req_data[10:0];
      end
    end
  end

endmodule

// File: rtl/msi_remap_dispatch_chk.sv
module msi_remap_dispatch_chk #(
  parameter logic [15:0] INVALID_SID = 16'hFFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [63:0] req_addr,
  input logic [31:0] req_data,
  input logic [15:0] req_sid,
  input logic        table_on,
  input logic        remap_cap,
  input logic [63:0] dte_w2,
  input logic [15:0] lookup_sid,
  input logic        res_valid,
  input logic [1:0]  res_kind,
  input logic [1:0]  res_err,
  input logic [63:0] pass_addr,
  input logic [31:0] pass_data,
  input logic        remap_valid
);

  AST_SID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sid != INVALID_SID) |-> (lookup_sid == req_sid)); // R1

  AST_PASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd0) |-> (pass_addr == $past(req_addr) && pass_data == $past(req_data))); // R2

  AST_CAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(table_on && dte_w2[0] && !remap_cap)) |-> (res_kind == 2'd3)); // R3

  AST_HIGH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(table_on && dte_w2[0] && req_addr[63:32] != 32'd0)) |-> (res_kind == 2'd3)); // R4

  AST_SMI_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(table_on && dte_w2[0] && req_data[10:8] == 3'd2)) |-> (res_kind == 2'd3)); // R5

  AST_REMAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    remap_valid |-> (res_valid && res_kind == 2'd1)); // R7

  AST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid)); // R10

  AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_err == ((res_kind == 2'd3) ? 2'd1 : (res_kind == 2'd2) ? 2'd3 : 2'd0))); // R10

endmodule

bind msi_remap_dispatch msi_remap_dispatch_chk #(.INVALID_SID(INVALID_SID)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_data(req_data), .req_sid(req_sid), .table_on(table_on), .remap_cap(remap_cap),
  .dte_w2(dte_w2), .lookup_sid(lookup_sid), .res_valid(res_valid), .res_kind(res_kind),
  .res_err(res_err), .pass_addr(pass_addr), .pass_data(pass_data), .remap_valid(remap_valid)
);

// File: tb/msi_remap_dispatch_test.sv
`timescale 1ns/1ps
module msi_remap_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [15:0] req_sid = '0;
  logic        table_on = 1'b0;
  logic        remap_cap = 1'b0;
  logic [63:0] dte_w0 = 64'h1111_2222_3333_4444;
  logic [63:0] dte_w1 = 64'h5555_6666_7777_8888;
  logic [63:0] dte_w2 = '0;
  logic [63:0] dte_w3 = '0;
  logic [15:0] lookup_sid;
  logic        res_valid;
  logic [1:0]  res_kind;
  logic [1:0]  res_err;
  logic [63:0] pass_addr;
  logic [31:0] pass_data;
  logic        remap_valid;
  logic [15:0] remap_sid;
  logic [44:0] remap_root;
  logic [10:0] remap_index;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msi_remap_dispatch uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input bit t, input bit en, input bit cap, input bit hi,
                                       input int mode, input int ctl, input bit dm, input int pe);
    if (!t || !en) return 2'd0;                       // R2
    if (!cap) return 2'd3;                            // R3
    if (hi) return 2'd3;                              // R4
    if (mode == 0 || mode == 1) begin                 // R6
      if (ctl == 0) return 2'd2;
      if (ctl == 1) return 2'd0;
      if (ctl == 2) return 2'd1;
      return 2'd3;
    end
    if (mode == 4 || mode == 5 || mode == 7) begin
      if (dm) return 2'd3;                            // R8
      if (mode == 4) return pe[2] ? 2'd0 : 2'd3;      // R9 bit 58
      if (mode == 5) return pe[0] ? 2'd0 : 2'd3;      // R9 bit 56
      return pe[1] ? 2'd0 : 2'd3;                     // R9 bit 57
    end
    return 2'd3;                                      // R5
  endfunction

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset res_valid", res_valid, 0);
    chk("R11 reset remap_valid", remap_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle res_valid", res_valid, 0);
    chk("R11 idle remap_valid", remap_valid, 0);

    for (int t = 0; t < 2; t++)
    for (int en = 0; en < 2; en++)
    for (int cap = 0; cap < 2; cap++)
    for (int hi = 0; hi < 2; hi++)
    for (int mode = 0; mode < 8; mode++)
    for (int ctl = 0; ctl < 4; ctl++)
    for (int dm = 0; dm < 2; dm++)
    for (int pe = 0; pe < 8; pe++) begin
      logic [1:0]  ek;
      logic [1:0]  ee;
      logic [15:0] esid;
      logic [44:0] root;
      n++;
      root = 45'(n * 40503 + 17);
      esid = (n % 4 == 0) ? 16'h00A0 : 16'(n);
      req_sid   = (n % 4 == 0) ? 16'hFFFF : 16'(n);
      table_on  = t[0];
      remap_cap = cap[0];
      req_addr  = {(hi != 0) ? 32'h0000_0001 : 32'h0, 32'hFEE0_0000 | 32'(n[7:0] << 4) | (dm != 0 ? 32'h4 : 32'h0)};
      req_data  = {21'(n * 3), 3'(mode), 8'(n)};
      dte_w2    = {2'b00, 2'(ctl), 9'h1FF, root, 5'b10101, 1'(en)};
      dte_w3    = {5'b11111, 3'(pe), 56'hFF_FFFF_FFFF_FFFF};
      req_valid = 1'b1;
      #1;
      chk("R1 lookup_sid", lookup_sid, esid);
      @(negedge clk);
      req_valid = 1'b0;
      ek = model(t[0], en[0], cap[0], hi[0], mode, ctl, dm[0], pe);
      ee = (ek == 2'd3) ? 2'd1 : (ek == 2'd2) ? 2'd3 : 2'd0;
      chk("R10 res_valid", res_valid, 1);
      chk("R2-R9 res_kind", res_kind, ek);
      chk("R10 res_err", res_err, ee);
      chk("R7 remap_valid", remap_valid, ek == 2'd1);
      if (ek == 2'd0) begin
        chk("R2 pass_addr", pass_addr, req_addr);
        chk("R2 pass_data", pass_data, req_data);
      end
      if (ek == 2'd1) begin
        chk("R7 remap_sid", remap_sid, esid);
        chk("R7 remap_root", remap_root, root);
        chk("R7 remap_index", remap_index, req_data[10:0]);
      end
    end

    @(negedge clk);
    chk("R10 strobe drops", res_valid, 0);
    chk("R7 remap strobe drops", remap_valid, 0);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule